// File: doc/BRIEF.md
# Horizontal Sync Jitter Regenerator

This block sits behind a link receiver whose horizontal sync output can wander by one pixel clock either way from line to line, while the data-enable strobe stays locked to the pixel data. It takes data enable, horizontal sync and vertical sync, all synchronous to the pixel clock. It rebuilds a horizontal sync pulse whose distance from data enable is the same on every line, so a panel controller downstream sees sync that does not move relative to the pixels.

On every line the block counts pixel clocks from the start of blanking, which is the first cycle with data enable low, to the leading edge of the incoming sync pulse. It keeps the last three counts and uses their median as the nominal offset. It also records the width of the most recent complete pulse and the idle level of the sync line. Once three lines have been measured, the block stops passing the incoming sync through. It drives a pulse of the learned width at the learned offset, with the learned polarity. During vertical blanking data enable never falls, so a line reference is generated from the measured line period. All three outputs leave through the same fixed four-clock pipeline.

Top module: `hsync_regen`

## Requirements
- R1: While reset is high, and until the pipeline refills after reset, all three outputs are low.
- R2: A line reference whose line is preceded by fewer than three measured sync leading edges passes the input sync through, delayed by exactly 4 clocks. From the first reference after the third leading edge, the output is regenerated, and it stays regenerated until reset.
- R3: Reference cycle index 0 is the first cycle with data enable low after a cycle with data enable high. The offset of a line is the index of the first cycle in that line where sync is at its active level. A regenerated pulse starts at the median of the three most recently measured offsets, taken when the line starts.
- R4: The regenerated pulse lasts as many clocks as the most recent incoming pulse that ended before the line started.
- R5: The idle level of sync is its value on the last data-enable-high cycle before a data-enable fall. The regenerated pulse is driven at the opposite level, so active-high and active-low sync both work.
- R6: Vertical sync and data enable appear at the outputs unchanged and delayed by exactly 4 clocks.
- R7: After two data-enable falls, the line period is the number of clocks between them. When data enable stays low for a full period, a new line reference starts there, and sync is measured and regenerated against it.
- R8: Once regenerated, the output depends only on the learned offset, width and polarity. A line whose incoming sync lands one clock early or late therefore gives the same output as a stable input with the same medians.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_in | input | 1 | Data enable, high during active pixels |
| hs_in | input | 1 | Incoming horizontal sync, possibly jittered |
| vs_in | input | 1 | Incoming vertical sync |
| de_out | output | 1 | Data enable delayed 4 clocks |
| hs_out | output | 1 | Regenerated (or, before lock, delayed) horizontal sync |
| vs_out | output | 1 | Vertical sync delayed 4 clocks |

## Verification
A wrong offset history, or a wrong median pick, shows as a regenerated pulse that starts one or two clocks off on the first line after the bad value entered. Each line start samples the three stored counts, so the error surfaces within one line. A stale width or polarity register shows as a pulse of the wrong length or level on that same next line. A broken flywheel shows only in vertical blanking, where the pulse drifts or falls back to the raw input within one line period. The bench compares every output cycle with a model built from the requirements. It also runs a jittered line sequence against a stable one and requires identical output.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Kind of line reference seen in a cycle.
  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_REAL = 2'd1,   // data enable fell this cycle
    REF_FLY  = 2'd2    // period elapsed with no fall (vertical blanking)
  } ref_kind_t;

  localparam int HSR_MED_W = 16;

  function automatic logic [HSR_MED_W-1:0] median3(
    input logic [HSR_MED_W-1:0] a,
    input logic [HSR_MED_W-1:0] b,
    input logic [HSR_MED_W-1:0] c
  );
    logic [HSR_MED_W-1:0] lo, hi, mid;
    lo  = (a < b) ? a : b;
    hi  = (a < b) ? b : a;
    mid = (hi < c) ? hi : c;
    return (lo > mid) ? lo : mid;
  endfunction

endpackage

// File: rtl/hsr_line_timer.sv
module hsr_line_timer
  import hsr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             de_in,
  output ref_kind_t        ref_kind,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             de_d;
  logic             started_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             sat;
  logic             fall;
  logic             wrap;

  assign sat     = (cnt_q == CNT_MAX);
  assign cnt_inc = sat ? cnt_q : cnt_q + 1'b1;
  assign fall    = de_d & ~de_in;
  assign wrap    = !fall && (period_q != '0) && !sat && (cnt_inc == period_q);

  always_comb begin
    if (fall)      ref_kind = REF_REAL;
    else if (wrap) ref_kind = REF_FLY;
    else           ref_kind = REF_NONE;
  end

  assign pos = (fall || wrap) ? '0 : cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_d      <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      period_q  <= '0;
    end else begin
      de_d  <= de_in;
      cnt_q <= pos;
      if (fall) begin
        started_q <= 1'b1;
        if (started_q) period_q <= sat ? '0 : cnt_inc;
      end
    end
  end

  // R7: the position counter never reaches a learned period
  p_count_in_period_r7: assert property (@(posedge clk) disable iff (rst)
    (period_q != '0) |-> (cnt_q < period_q));

  // R7: a flywheel reference needs an earlier real reference
  p_fly_after_real_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_kind == REF_FLY) |-> started_q);

endmodule

// File: rtl/hsr_edge_meter.sv
module hsr_edge_meter
  import hsr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  input  ref_kind_t        ref_kind,
  input  logic [CNT_W-1:0] pos,
  output logic             idle_lvl,
  output logic [CNT_W-1:0] med_off,
  output logic [CNT_W-1:0] last_width,
  output logic             three_seen
);
  localparam int HIST = 3;
  localparam logic [CNT_W-1:0] W_MAX = '1;

  logic             hs_d;
  logic             idle_q;
  logic             armed_q;
  logic             inpulse_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] hist_q [HIST];
  logic [1:0]       nmeas_q;
  logic             act_in;
  logic             armed_cur;
  logic             lead;

  assign idle_lvl  = (ref_kind == REF_REAL) ? hs_d : idle_q;
  assign act_in    = hs_in ^ idle_lvl;
  assign armed_cur = (ref_kind != REF_NONE) | armed_q;
  assign lead      = armed_cur & act_in & ~inpulse_q;

  assign med_off    = CNT_W'(median3(HSR_MED_W'(hist_q[0]), HSR_MED_W'(hist_q[1]),
                                     HSR_MED_W'(hist_q[2])));
  assign last_width = width_q;
  assign three_seen = (nmeas_q == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d      <= 1'b0;
      idle_q    <= 1'b0;
      armed_q   <= 1'b0;
      inpulse_q <= 1'b0;
      wcnt_q    <= '0;
      width_q   <= '0;
      nmeas_q   <= '0;
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else begin
      hs_d   <= hs_in;
      idle_q <= idle_lvl;
      if (lead) begin
        for (int i = HIST-1; i > 0; i--) hist_q[i] <= hist_q[i-1];
        hist_q[0] <= pos;
        if (nmeas_q != 2'd3) nmeas_q <= nmeas_q + 2'd1;
        armed_q   <= 1'b0;
        inpulse_q <= 1'b1;
        wcnt_q    <= CNT_W'(1);
      end else begin
        armed_q <= armed_cur;
        if (inpulse_q) begin
          if (act_in) begin
            if (wcnt_q != W_MAX) wcnt_q <= wcnt_q + 1'b1;
          end else begin
            width_q   <= wcnt_q;
            inpulse_q <= 1'b0;
          end
        end
      end
    end
  end

  // R4: by the second measured edge a complete width is on record
  p_width_known_r4: assert property (@(posedge clk) disable iff (rst)
    (nmeas_q >= 2'd2) |-> (width_q != '0));

  // R3: a leading edge stores the position supplied by the line timer
  p_edge_stores_pos_r3: assert property (@(posedge clk) disable iff (rst)
    lead |=> (hist_q[0] == $past(pos)));

endmodule

// File: rtl/hsr_delay_line.sv
module hsr_delay_line #(
  parameter int W = 3,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [D];

  for (genvar i = 0; i < D; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[D-1];

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int LAT   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic de_in,
  input  logic hs_in,
  input  logic vs_in,
  output logic de_out,
  output logic hs_out,
  output logic vs_out
);
  localparam int SIG_W = 3;

  ref_kind_t        ref_kind;
  logic [CNT_W-1:0] pos;
  logic             idle_lvl;
  logic [CNT_W-1:0] med_off;
  logic [CNT_W-1:0] last_width;
  logic             three_seen;

  logic             lock_q;
  logic [CNT_W-1:0] med_q;
  logic [CNT_W-1:0] wid_q;
  logic             is_ref;
  logic             lock_cur;
  logic [CNT_W-1:0] med_cur;
  logic [CNT_W-1:0] wid_cur;
  logic [CNT_W:0]   win_end;
  logic             regen_act;
  logic             hs_sel;
  logic [SIG_W-1:0] pipe_in;
  logic [SIG_W-1:0] pipe_out;

  hsr_line_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .de_in    (de_in),
    .ref_kind (ref_kind),
    .pos      (pos)
  );

  hsr_edge_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .hs_in      (hs_in),
    .ref_kind   (ref_kind),
    .pos        (pos),
    .idle_lvl   (idle_lvl),
    .med_off    (med_off),
    .last_width (last_width),
    .three_seen (three_seen)
  );

  // Line parameters are taken at the line reference and held for the line.
  assign is_ref   = (ref_kind != REF_NONE);
  assign lock_cur = is_ref ? three_seen : lock_q;
  assign med_cur  = is_ref ? med_off    : med_q;
  assign wid_cur  = is_ref ? last_width : wid_q;

  assign win_end   = {1'b0, med_cur} + {1'b0, wid_cur};
  assign regen_act = (pos >= med_cur) && ({1'b0, pos} < win_end);
  assign hs_sel    = lock_cur ? (regen_act ^ idle_lvl) : hs_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      med_q  <= '0;
      wid_q  <= '0;
    end else begin
      lock_q <= lock_cur;
      med_q  <= med_cur;
      wid_q  <= wid_cur;
    end
  end

  assign pipe_in = {de_in, vs_in, hs_sel};

  hsr_delay_line #(.W(SIG_W), .D(LAT)) u_align (
    .clk  (clk),
    .rst  (rst),
    .din  (pipe_in),
    .dout (pipe_out)
  );

  assign de_out = pipe_out[2];
  assign vs_out = pipe_out[1];
  assign hs_out = pipe_out[0];

  // R2: once regeneration starts it holds until reset
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R2: regeneration needs three measured edges at some line start
  p_lock_needs_three_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(three_seen));

endmodule

// File: tb/hsync_regen_bench.sv
`timescale 1ns/1ps
module hsync_regen_bench;
  localparam int LAT = 4;
  localparam int P   = 24;   // line length in clocks
  localparam int ACT = 10;   // active cycles at the end of a line
  localparam int PRE = 10;   // data-enable-high cycles before the first line

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic de_o, hs_o, vs_o;

  always #2.5 clk = ~clk;

  hsync_regen u_hsync_regen (
    .clk(clk), .rst(rst), .de_in(de_i), .hs_in(hs_i), .vs_in(vs_i),
    .de_out(de_o), .hs_out(hs_o), .vs_out(vs_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int k        = 0;
  string cur_tag = "R2";
  logic exp_hs [8];
  logic exp_vs [8];
  logic exp_de [8];
  logic rec [512];
  int rec_mode = 0;
  int off_a [16];
  int wid_a [16];
  int act_a [16];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle=%0d actual=%b expected=%b", tag, what, k, act, exp);
    end
  endtask

  function automatic int med3(input int a, input int b, input int c);
    int lo, hi, mid;
    lo  = (a < b) ? a : b;
    hi  = (a < b) ? b : a;
    mid = (hi < c) ? hi : c;
    return (lo > mid) ? lo : mid;
  endfunction

  task automatic step(input logic d, input logic h, input logic v, input logic e);
    @(posedge clk);
    #1;
    de_i = d; hs_i = h; vs_i = v;
    exp_hs[k % 8] = e; exp_vs[k % 8] = v; exp_de[k % 8] = d;
    @(negedge clk);
    if (k >= LAT) begin
      chk(cur_tag, "hs_out", hs_o, exp_hs[(k - LAT) % 8]);
      chk("R6", "vs_out", vs_o, exp_vs[(k - LAT) % 8]);
      chk("R6", "de_out", de_o, exp_de[(k - LAT) % 8]);
      if (rec_mode == 1) rec[k] = hs_o;
      if (rec_mode == 2 && k >= PRE + 3*P + LAT)
        chk("R8", "hs_out vs stable run", hs_o, rec[k]);
    end
    k++;
  endtask

  task automatic do_reset(input logic pol);
    rst = 1'b1; de_i = 1'b0; vs_i = 1'b0; hs_i = ~pol;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "hs_out in reset", hs_o, 1'b0);
    chk("R1", "vs_out in reset", vs_o, 1'b0);
    chk("R1", "de_out in reset", de_o, 1'b0);
    @(posedge clk);
    #1 rst = 1'b0;
    k = 0;
  endtask

  task automatic fill(input int off, input int wid);
    for (int i = 0; i < 16; i++) begin
      off_a[i] = off; wid_a[i] = wid; act_a[i] = 1;
    end
  endtask

  // Drives nlines lines; expected sync comes from the requirement model.
  task automatic run(input int nlines, input logic pol);
    int h0, h1, h2, nlead, wprev, med, wl;
    logic lockl, raw, e;
    h0 = 0; h1 = 0; h2 = 0; nlead = 0; wprev = 0;
    for (int i = 0; i < PRE; i++) step(1'b1, ~pol, 1'b0, ~pol);
    for (int n = 0; n < nlines; n++) begin
      lockl = (nlead >= 3);
      med   = med3(h0, h1, h2);
      wl    = wprev;
      for (int p = 0; p < P; p++) begin
        raw = (p >= off_a[n] && p < off_a[n] + wid_a[n]) ? pol : ~pol;
        if (lockl) e = (p >= med && p < med + wl) ? pol : ~pol;
        else       e = raw;
        step((act_a[n] != 0) && (p >= P - ACT), raw, (n % 4) == 2, e);
      end
      h2 = h1; h1 = h0; h0 = off_a[n];
      nlead++;
      wprev = wid_a[n];
    end
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    do_reset(1'b1);
    @(negedge clk);
    chk("R1", "hs_out after release", hs_o, 1'b0);
    chk("R1", "vs_out after release", vs_o, 1'b0);
  endtask

  task automatic t_prelock();   // R2 passthrough, then switch at line 3
    cur_tag = "R2";
    do_reset(1'b1);
    fill(5, 4);
    off_a[0] = 6; off_a[1] = 4;
    run(8, 1'b1);
  endtask

  task automatic t_median();    // R3 median selection across changing offsets
    cur_tag = "R3";
    do_reset(1'b1);
    fill(5, 4);
    off_a[3] = 7; off_a[4] = 7; off_a[5] = 3; off_a[6] = 3; off_a[7] = 7; off_a[9] = 6;
    run(10, 1'b1);
  endtask

  task automatic t_jitter();    // R8 jittered input equals stable input
    cur_tag = "R8";
    do_reset(1'b1);
    fill(5, 4);
    rec_mode = 1;
    run(10, 1'b1);
    rec_mode = 0;
    do_reset(1'b1);
    fill(5, 4);
    off_a[3] = 4; off_a[4] = 6; off_a[6] = 4; off_a[7] = 6; off_a[9] = 4;
    rec_mode = 2;
    run(10, 1'b1);
    rec_mode = 0;
  endtask

  task automatic t_width();     // R4 width follows the latest pulse
    cur_tag = "R4";
    do_reset(1'b1);
    fill(5, 3);
    wid_a[3] = 5; wid_a[4] = 5; wid_a[5] = 2; wid_a[6] = 6; wid_a[7] = 1; wid_a[8] = 4;
    run(10, 1'b1);
  endtask

  task automatic t_polarity();  // R5 active-low sync
    cur_tag = "R5";
    do_reset(1'b0);
    fill(5, 3);
    off_a[0] = 4; off_a[2] = 6; off_a[4] = 4; off_a[5] = 6;
    run(9, 1'b0);
  endtask

  task automatic t_flywheel();  // R7 references during data-enable-low lines
    cur_tag = "R7";
    do_reset(1'b1);
    fill(5, 4);
    off_a[1] = 6; off_a[2] = 4; off_a[4] = 6; off_a[5] = 4; off_a[8] = 6;
    act_a[2] = 0; act_a[3] = 0; act_a[4] = 0; act_a[7] = 0;
    run(10, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_prelock();
    t_median();
    t_jitter();
    t_width();
    t_polarity();
    t_flywheel();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule